// File: doc/BRIEF.md
# Segmented Logical-to-Physical Address Mapper

The mapper turns a request address into a location in one of three memories: the shared unified memory, the on-chip instruction memory or the on-chip data memory. A request comes in one of three kinds. A system request carries a 32-bit address whose top byte picks either a direct physical window or one of the two logical windows. A data-logical request and an instruction-logical request send their low 24 bits straight into the matching logical translator. Six 16-bit map registers steer the logical windows: four cover the data logical space and two cover the instruction logical space. Each register names a memory space and a segment, and a data map can also send its block into one of sixteen I/O windows.

For every request the block returns four things. These are the physical address, tagged with the memory it lands in, the number of requested bytes that fit before the next block or segment edge, and an error flag for regions that cannot be reached. Map registers are written through a small write port that decodes the data-memory offsets where the registers sit. Translation is combinational from the registered maps. A register write is therefore seen by translations from the next clock cycle on.

Top module: `addr_mapper`

## Requirements
- R1: After reset both instruction maps hold 0x1000, data maps 0 to 2 hold 0x2000 and data map 3 holds 0x0000. As a result, data-logical offset 0x0000-0xBFFF maps one-to-one into data memory, 0xC000-0xFFFF maps to unified offset minus 0xC000, and instruction-logical offset x below 0x40000 maps to instruction memory at x.
- R2: A write with `wr_en` high stores `wr_data` into instruction map i at 0xFF00+2i, or into data map i at 0xFF08+2i, and changes translations from the next cycle. A write to any other address, odd addresses included, changes no translation.
- R3: A write to 0xFF04 updates data map 2, exactly as a write to 0xFF0C does.
- R4: When a result lands in data memory and offset bits [15:8] are all ones, offset bits [23:16] are cleared. If the remaining offset is then 0xFF04, it is replaced by 0xFF0C.
- R5: For a system request, address bits [31:24] pick the window. 0x00, 0x01 and 0x02 select unified, instruction and data memory directly, with offset = bits [23:0] and room = 0x20000 − (offset mod 0x20000). On success, `phys_addr` = {6'b0, mem_sel, offset[23:0]}, with `mem_sel` 0 = unified, 1 = instruction and 2 = data.
- R6: A system window byte other than 0x00, 0x01, 0x02, 0x10 and 0x11, or `req_kind` = 3, is an error. An error sets `xlate_err` = 1, `mem_sel` = 3, `phys_addr` = 0 and `fit_len` = 0.
- R7: A data-logical offset (window 0x10, or `req_kind` = 1) of 0x10000 or more is an error.
- R8: For a data offset o, the register index is o / 0x4000, the block offset is b = o mod 0x4000 and the room is 0x4000 − b. When map bit 15 is clear, map bits [13:12] give the space and bits [9:0] give the segment s. Space 0 yields unified s·0x4000+b. Space 1 yields instruction s·0x4000+b. Space 2 yields data (s·0x10000 + o) mod 2^24.
- R9: A data map with bit 15 clear and space 3 makes the request an error.
- R10: A data map with bit 15 set selects I/O. Take k = (b / 0x1000) mod 4 and let n be map nibble 3−k, where nibble j is bits [4j+3:4j]. The result is data n·0x10000 + 0xC000 + b.
- R11: An instruction-logical offset (window 0x11, or `req_kind` = 2) of 0x40000 or more is an error. Otherwise the register index is o / 0x20000, b = o mod 0x20000 and the room is 0x20000 − b. Map bits [13:12] give the space and bits [6:0] give the segment s. Space 0 yields unified s·0x20000+b, space 1 yields instruction o, and space 2 is an error.
- R12: In instruction space 3, t = b mod 0x800 and the result is instruction offset t with room 0x800 − t.
- R13: `fit_len` = min(`req_len`, room) and appears in the same cycle as the request, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the map registers |
| rst_n | input | 1 | Active-low synchronous reset |
| req_kind | input | 2 | 0 system, 1 data logical, 2 instruction logical, 3 invalid |
| req_addr | input | 32 | Request address |
| req_len | input | LEN_W | Requested byte count |
| wr_en | input | 1 | Map register write strobe |
| wr_addr | input | 16 | Data-memory offset of the write |
| wr_data | input | 16 | Value to store |
| phys_addr | output | 32 | {6'b0, memory code, 24-bit offset}, zero on error |
| mem_sel | output | 2 | 0 unified, 1 instruction, 2 data, 3 none |
| fit_len | output | LEN_W | Bytes of the request that fit before the edge |
| xlate_err | output | 1 | Unsupported region |

## Verification
The only internal state is the six map registers. A wrong register value shows up on the first translation that reads it: the memory code, the segment bits of the offset or the error flag comes out wrong in the same cycle as the request. A write that lands in the wrong register, or is lost, therefore becomes visible one cycle after the write, as soon as a request crosses that register's block. The clipped length and the register-window fixup expose arithmetic faults on any single request, whatever the register contents.

// File: rtl/mapxl_pkg.sv
`timescale 1ns/1ps
package mapxl_pkg;
    localparam int OFF_W  = 24;
    localparam int ROOM_W = 25;
    localparam int MAP_W  = 16;

    localparam logic [15:0] IMAP_OFF  = 16'hFF00;
    localparam logic [15:0] DMAP_OFF  = 16'hFF08;
    localparam logic [15:0] ALIAS_OFF = 16'hFF04;
    localparam logic [15:0] ALIAS_TGT = 16'hFF0C;
    localparam logic [7:0]  REG_PAGE  = 8'hFF;
    localparam int          ALIAS_IDX = 2;

    typedef enum logic [1:0] {
        MEM_UNI  = 2'd0,
        MEM_INS  = 2'd1,
        MEM_DAT  = 2'd2,
        MEM_NONE = 2'd3
    } mem_e;

    typedef enum logic [1:0] {
        REQ_SYS  = 2'd0,
        REQ_DLOG = 2'd1,
        REQ_ILOG = 2'd2,
        REQ_BAD  = 2'd3
    } req_e;

    typedef struct packed {
        logic              err;
        mem_e              mem;
        logic [OFF_W-1:0]  off;
        logic [ROOM_W-1:0] room;
    } xres_t;
endpackage

// File: rtl/mapxl_regs.sv
`timescale 1ns/1ps
module mapxl_regs
    import mapxl_pkg::*;
#(
    parameter int NDMAP = 4,
    parameter int NIMAP = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [15:0]                 wr_addr,
    input  logic [15:0]                 wr_data,
    output logic [NDMAP-1:0][MAP_W-1:0] dmap_q,
    output logic [NIMAP-1:0][MAP_W-1:0] imap_q
);
    localparam logic [MAP_W-1:0] DMAP_RST      = 16'h2000;
    localparam logic [MAP_W-1:0] DMAP_LAST_RST = 16'h0000;
    localparam logic [MAP_W-1:0] IMAP_RST      = 16'h1000;

    generate
        for (genvar i = 0; i < NDMAP; i++) begin : g_dmap
            localparam logic [15:0] MY_ADDR = DMAP_OFF + 16'(2 * i);
            localparam logic [MAP_W-1:0] RST_VAL = (i == NDMAP - 1) ? DMAP_LAST_RST : DMAP_RST;
            logic             hit;
            logic [MAP_W-1:0] q;
            always_comb begin
                hit = wr_en && ((wr_addr == MY_ADDR) ||
                                ((i == ALIAS_IDX) && (wr_addr == ALIAS_OFF)));
            end
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= RST_VAL;
                else if (hit) q <= wr_data;
            end
            assign dmap_q[i] = q;
        end

        for (genvar j = 0; j < NIMAP; j++) begin : g_imap
            localparam logic [15:0] MY_ADDR = IMAP_OFF + 16'(2 * j);
            logic             hit;
            logic [MAP_W-1:0] q;
            always_comb hit = wr_en && (wr_addr == MY_ADDR);
            always_ff @(posedge clk) begin
                if (!rst_n)   q <= IMAP_RST;
                else if (hit) q <= wr_data;
            end
            assign imap_q[j] = q;
        end
    endgenerate

    // R3: the shadow address lands in data map 2 one cycle later
    assert_alias_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ALIAS_OFF) |=> (dmap_q[ALIAS_IDX] == $past(wr_data)));

    // R2: first instruction map takes a write at its offset
    assert_imap_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == IMAP_OFF) |=> (imap_q[0] == $past(wr_data)));

    // R2: without a write strobe no map changes
    assert_maps_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && $past(rst_n)) |=> ($stable(dmap_q) && $stable(imap_q)));
endmodule

// File: rtl/mapxl_dmap.sv
`timescale 1ns/1ps
module mapxl_dmap
    import mapxl_pkg::*;
#(
    parameter int NDMAP = 4,
    parameter int BLK_W = 14
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [OFF_W-1:0]            off,
    input  logic [NDMAP-1:0][MAP_W-1:0] map_q,
    output xres_t                       res
);
    localparam int RNO_W   = $clog2(NDMAP);
    localparam int RANGE_W = BLK_W + RNO_W;
    localparam int SEG_W   = 10;
    localparam int IO_BIT  = 15;
    localparam int SUB_LSB = 12;
    localparam int NIB_W   = 4;
    localparam logic [OFF_W-1:0]  IO_WIN = 24'h00C000;
    localparam logic [ROOM_W-1:0] SPAN   = ROOM_W'(1) << BLK_W;

    logic [RNO_W-1:0] regno;
    logic [BLK_W-1:0] boff;
    logic [MAP_W-1:0] map;
    logic [1:0]       space;
    logic [1:0]       sub;
    logic [SEG_W-1:0] seg;
    logic [NIB_W-1:0] nib;
    logic             oor;
    logic             map_unused;

    always_comb begin
        oor        = |off[OFF_W-1:RANGE_W];
        regno      = off[RANGE_W-1:BLK_W];
        boff       = off[BLK_W-1:0];
        map        = map_q[regno];
        space      = map[13:12];
        seg        = map[SEG_W-1:0];
        sub        = boff[SUB_LSB+1:SUB_LSB];
        nib        = NIB_W'(map >> (NIB_W * (2'd3 - sub)));
        map_unused = ^{map[14], map[11:10]};

        res.err  = 1'b0;
        res.mem  = MEM_NONE;
        res.off  = '0;
        res.room = SPAN - ROOM_W'(boff);
        if (oor) begin
            res.err = 1'b1;
        end else if (map[IO_BIT]) begin
            res.mem = MEM_DAT;
            res.off = (OFF_W'(nib) << 16) + IO_WIN + OFF_W'(boff);
        end else begin
            unique case (space)
                2'd0: begin
                    res.mem = MEM_UNI;
                    res.off = OFF_W'({seg, boff});
                end
                2'd1: begin
                    res.mem = MEM_INS;
                    res.off = OFF_W'({seg, boff});
                end
                2'd2: begin
                    res.mem = MEM_DAT;
                    res.off = (OFF_W'(seg) << 16) + OFF_W'(off[RANGE_W-1:0]);
                end
                default: res.err = 1'b1;
            endcase
        end
    end

    // R10: an I/O result sits in the top quarter of a 64 KiB page at the block offset
    assert_io_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!oor && map[IO_BIT]) |-> (res.off[15:14] == 2'b11 && res.off[13:0] == 14'(boff)));

    // R7: offsets beyond the mapped range never translate
    assert_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oor |-> res.err);

    // R8: a block always leaves at least one byte and never more than a block
    assert_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res.err |-> (res.room != '0 && res.room <= SPAN));

    // R9: reserved space with I/O bit clear fails
    assert_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!oor && !map[IO_BIT] && space == 2'd3) |-> res.err);
endmodule

// File: rtl/mapxl_imap.sv
`timescale 1ns/1ps
module mapxl_imap
    import mapxl_pkg::*;
#(
    parameter int NIMAP = 2,
    parameter int BLK_W = 17
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [OFF_W-1:0]            off,
    input  logic [NIMAP-1:0][MAP_W-1:0] map_q,
    output xres_t                       res
);
    localparam int RNO_W   = $clog2(NIMAP);
    localparam int RANGE_W = BLK_W + RNO_W;
    localparam int SEG_W   = 7;
    localparam int TEST_W  = 11;
    localparam logic [ROOM_W-1:0] SPAN      = ROOM_W'(1) << BLK_W;
    localparam logic [ROOM_W-1:0] TEST_ROOM = ROOM_W'(1) << TEST_W;
    localparam logic [OFF_W-1:0]  TEST_TOP  = OFF_W'(1) << TEST_W;

    logic [RNO_W-1:0] regno;
    logic [BLK_W-1:0] boff;
    logic [MAP_W-1:0] map;
    logic [1:0]       space;
    logic [SEG_W-1:0] seg;
    logic             oor;
    logic             map_unused;

    always_comb begin
        oor        = |off[OFF_W-1:RANGE_W];
        regno      = off[RANGE_W-1:BLK_W];
        boff       = off[BLK_W-1:0];
        map        = map_q[regno];
        space      = map[13:12];
        seg        = map[SEG_W-1:0];
        map_unused = ^{map[15:14], map[11:SEG_W]};

        res.err  = 1'b0;
        res.mem  = MEM_NONE;
        res.off  = '0;
        res.room = SPAN - ROOM_W'(boff);
        if (oor) begin
            res.err = 1'b1;
        end else begin
            unique case (space)
                2'd0: begin
                    res.mem = MEM_UNI;
                    res.off = OFF_W'({seg, boff});
                end
                2'd1: begin
                    res.mem = MEM_INS;
                    res.off = OFF_W'(off[RANGE_W-1:0]);
                end
                2'd3: begin
                    res.mem  = MEM_INS;
                    res.off  = OFF_W'(boff[TEST_W-1:0]);
                    res.room = TEST_ROOM - ROOM_W'(boff[TEST_W-1:0]);
                end
                default: res.err = 1'b1;
            endcase
        end
    end

    // R12: the test window wraps inside its 2 KiB span
    assert_test_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!oor && space == 2'd3) |-> (res.off < TEST_TOP && res.room <= TEST_ROOM && res.room != '0));

    // R11: space 2 is not a valid instruction mapping
    assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (space == 2'd2) |-> res.err);
endmodule

// File: rtl/addr_mapper.sv
`timescale 1ns/1ps
module addr_mapper
    import mapxl_pkg::*;
#(
    parameter int NDMAP   = 4,
    parameter int NIMAP   = 2,
    parameter int DBLK_W  = 14,
    parameter int IBLK_W  = 17,
    parameter int SEGSZ_W = 17,
    parameter int LEN_W   = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       req_kind,
    input  logic [31:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wr_en,
    input  logic [15:0]      wr_addr,
    input  logic [15:0]      wr_data,
    output logic [31:0]      phys_addr,
    output logic [1:0]       mem_sel,
    output logic [LEN_W-1:0] fit_len,
    output logic             xlate_err
);
    localparam logic [7:0] WIN_UNI  = 8'h00;
    localparam logic [7:0] WIN_INS  = 8'h01;
    localparam logic [7:0] WIN_DAT  = 8'h02;
    localparam logic [7:0] WIN_DLOG = 8'h10;
    localparam logic [7:0] WIN_ILOG = 8'h11;
    localparam logic [ROOM_W-1:0] SEG_SPAN = ROOM_W'(1) << SEGSZ_W;

    logic [NDMAP-1:0][MAP_W-1:0] dmap_q;
    logic [NIMAP-1:0][MAP_W-1:0] imap_q;
    logic [OFF_W-1:0]            req_off;
    logic [7:0]                  win;
    xres_t                       dres, ires, pres, sel;
    logic [OFF_W-1:0]            off_fix;
    logic [ROOM_W-1:0]           len_wide;
    req_e                        kind;

    assign req_off = req_addr[OFF_W-1:0];
    assign win     = req_addr[31:24];

    mapxl_regs #(.NDMAP(NDMAP), .NIMAP(NIMAP)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dmap_q(dmap_q), .imap_q(imap_q)
    );

    mapxl_dmap #(.NDMAP(NDMAP), .BLK_W(DBLK_W)) u_dmap (
        .clk(clk), .rst_n(rst_n), .off(req_off), .map_q(dmap_q), .res(dres)
    );

    mapxl_imap #(.NIMAP(NIMAP), .BLK_W(IBLK_W)) u_imap (
        .clk(clk), .rst_n(rst_n), .off(req_off), .map_q(imap_q), .res(ires)
    );

    // direct physical windows
    always_comb begin
        pres.err  = 1'b0;
        pres.mem  = mem_e'(win[1:0]);
        pres.off  = req_off;
        pres.room = SEG_SPAN - ROOM_W'(req_off[SEGSZ_W-1:0]);
    end

    // window / request-kind selection
    always_comb begin
        kind     = req_e'(req_kind);
        sel.err  = 1'b1;
        sel.mem  = MEM_NONE;
        sel.off  = '0;
        sel.room = '0;
        unique case (kind)
            REQ_SYS: begin
                case (win)
                    WIN_UNI, WIN_INS, WIN_DAT: sel = pres;
                    WIN_DLOG:                  sel = dres;
                    WIN_ILOG:                  sel = ires;
                    default:                   ;
                endcase
            end
            REQ_DLOG: sel = dres;
            REQ_ILOG: sel = ires;
            REQ_BAD:  ;
        endcase
    end

    // register page fixup and outputs
    always_comb begin
        off_fix = sel.off;
        if (sel.mem == MEM_DAT && sel.off[15:8] == REG_PAGE) begin
            off_fix = {8'h00, sel.off[15:0]};
            if (sel.off[15:0] == ALIAS_OFF) off_fix[15:0] = ALIAS_TGT;
        end
        len_wide = ROOM_W'(req_len);
        if (sel.err) begin
            xlate_err = 1'b1;
            mem_sel   = MEM_NONE;
            phys_addr = '0;
            fit_len   = '0;
        end else begin
            xlate_err = 1'b0;
            mem_sel   = sel.mem;
            phys_addr = {6'b0, sel.mem, off_fix};
            fit_len   = (len_wide > sel.room) ? LEN_W'(sel.room) : req_len;
        end
    end

    // R13: never grant more than asked
    assert_fit_bound_R13: assert property (@(posedge clk) disable iff (!rst_n)
        fit_len <= req_len);

    // R6: an error clears every result field
    assert_err_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xlate_err |-> (fit_len == '0 && phys_addr == '0 && mem_sel == 2'd3));

    // R5: a valid result carries its memory code in the address tag
    assert_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !xlate_err |-> (phys_addr[25:24] == mem_sel && mem_sel != 2'd3 && phys_addr[31:26] == 6'b0));

    // R4: the shadow offset never reaches data memory unredirected
    assert_alias_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!xlate_err && mem_sel == 2'd2) |-> (phys_addr[15:0] != ALIAS_OFF));
endmodule

// File: tb/addr_mapper_test.sv
`timescale 1ns/1ps
module addr_mapper_test;
    localparam int LEN_W = 18;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       req_kind = 2'd0;
    logic [31:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             wr_en = 1'b0;
    logic [15:0]      wr_addr = '0;
    logic [15:0]      wr_data = '0;
    logic [31:0]      phys_addr;
    logic [1:0]       mem_sel;
    logic [LEN_W-1:0] fit_len;
    logic             xlate_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] sh_d [4];
    logic [15:0] sh_i [2];

    always #10 clk = ~clk;

    addr_mapper uut (
        .clk(clk), .rst_n(rst_n), .req_kind(req_kind), .req_addr(req_addr),
        .req_len(req_len), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .phys_addr(phys_addr), .mem_sel(mem_sel), .fit_len(fit_len), .xlate_err(xlate_err)
    );

    function automatic void model(input int kind, input logic [31:0] a, input longint len,
                                  output bit err, output int mem, output longint off,
                                  output longint fit, output string tag);
        longint o, room, b, r, t;
        int path, seg, sp, sub, nib;
        logic [15:0] m;
        o = longint'(a & 32'h00FF_FFFF);
        seg = int'(a >> 24);
        err = 0; mem = 3; off = 0; room = 0; tag = "R6";
        if (kind == 0) begin
            if (seg <= 2) path = 0;
            else if (seg == 'h10) path = 1;
            else if (seg == 'h11) path = 2;
            else path = 3;
        end else path = kind;
        case (path)
            0: begin
                mem = seg; off = o; room = 'h20000 - (o % 'h20000); tag = "R5";
            end
            1: begin
                if (o >= 'h10000) begin err = 1; tag = "R7"; end
                else begin
                    r = o / 'h4000; b = o % 'h4000; m = sh_d[r]; room = 'h4000 - b;
                    if (m[15]) begin
                        sub = int'((b / 'h1000) % 4);
                        nib = int'((m >> (4 * (3 - sub))) & 16'hF);
                        mem = 2; off = (nib * 'h10000 + 'hC000 + b) & 'hFFFFFF; tag = "R10";
                    end else begin
                        sp = int'((m >> 12) & 3); t = m & 'h3FF; tag = "R8";
                        case (sp)
                            0: begin mem = 0; off = t * 'h4000 + b; end
                            1: begin mem = 1; off = t * 'h4000 + b; end
                            2: begin mem = 2; off = (t * 'h10000 + r * 'h4000 + b) & 'hFFFFFF; end
                            default: begin err = 1; tag = "R9"; end
                        endcase
                    end
                end
            end
            2: begin
                if (o >= 'h40000) begin err = 1; tag = "R11"; end
                else begin
                    r = o / 'h20000; b = o % 'h20000; m = sh_i[r]; room = 'h20000 - b;
                    sp = int'((m >> 12) & 3); t = m & 'h7F; tag = "R11";
                    case (sp)
                        0: begin mem = 0; off = t * 'h20000 + b; end
                        1: begin mem = 1; off = r * 'h20000 + b; end
                        2: err = 1;
                        default: begin
                            mem = 1; off = b % 'h800; room = 'h800 - off; tag = "R12";
                        end
                    endcase
                end
            end
            default: err = 1;
        endcase
        if (!err && mem == 2 && ((off >> 8) & 'hFF) == 'hFF) begin
            off = off & 'hFFFF;
            if (off == 'hFF04) off = 'hFF0C;
        end
        if (err) begin mem = 3; off = 0; fit = 0; end
        else fit = (len < room) ? len : room;
    endfunction

    task automatic check(input logic [1:0] k, input logic [31:0] a, input longint len, input string want);
        bit e; int m; longint o, f; string tag;
        logic [31:0] ep;
        @(negedge clk);
        req_kind = k; req_addr = a; req_len = LEN_W'(len);
        #3;
        model(int'(k), a, len, e, m, o, f, tag);
        if (want != "") tag = want;
        ep = e ? 32'h0 : {6'b0, m[1:0], o[23:0]};
        n_chk++;
        if (xlate_err !== e || phys_addr !== ep || mem_sel !== m[1:0] || fit_len !== LEN_W'(f)) begin
            n_bad++;
            $display("FAIL %s kind=%0d addr=%h len=%h : got err=%b phys=%h mem=%0d fit=%h, expected err=%b phys=%h mem=%0d fit=%h",
                     tag, k, a, len, xlate_err, phys_addr, mem_sel, fit_len, e, ep, m[1:0], LEN_W'(f));
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < 4; i++)
            if (a == 16'hFF08 + 16'(2 * i) || (i == 2 && a == 16'hFF04)) sh_d[i] = d;
        for (int i = 0; i < 2; i++)
            if (a == 16'hFF00 + 16'(2 * i)) sh_i[i] = d;
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, got hang, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        sh_d[0] = 16'h2000; sh_d[1] = 16'h2000; sh_d[2] = 16'h2000; sh_d[3] = 16'h0000;
        sh_i[0] = 16'h1000; sh_i[1] = 16'h1000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset maps
        check(2'd1, 32'h0000_0123, 4, "R1");
        check(2'd1, 32'h0000_C010, 8, "R1");
        check(2'd2, 32'h0002_0004, 2, "R1");
        check(2'd0, 32'h1000_BFFE, 16, "R1");
        // R13 zero length and same-cycle clipping
        check(2'd1, 32'h0000_3FF0, 0, "R13");
        check(2'd1, 32'h0000_3FF0, 'h100, "R13");
        // R5 direct windows
        check(2'd0, 32'h0001_FFF0, 'h40, "R5");
        check(2'd0, 32'h0100_0010, 5, "R5");
        // R6 bad windows and kind
        check(2'd0, 32'h0500_0000, 4, "R6");
        check(2'd0, 32'h1200_0000, 4, "R6");
        check(2'd3, 32'h0000_0000, 4, "R6");
        // R7 / R11 range limits
        check(2'd1, 32'h0001_0000, 4, "R7");
        check(2'd0, 32'h1000_FFFF, 4, "R7");
        check(2'd2, 32'h0004_0000, 4, "R11");
        check(2'd2, 32'h0003_FFFF, 4, "R11");
        // R9 reserved data space
        do_write(16'hFF0A, 16'h3000);
        check(2'd1, 32'h0000_4000, 4, "R9");
        // R10 I/O space nibble pick
        do_write(16'hFF08, 16'h9234);
        check(2'd1, 32'h0000_2010, 4, "R10");
        check(2'd1, 32'h0000_0100, 4, "R10");
        // R3 alias write
        do_write(16'hFF04, 16'h2001);
        check(2'd1, 32'h0000_8004, 4, "R3");
        // R2 ignored addresses
        do_write(16'hFF06, 16'hFFFF);
        do_write(16'hFF09, 16'hFFFF);
        do_write(16'hFF10, 16'hFFFF);
        check(2'd1, 32'h0000_8004, 4, "R2");
        check(2'd1, 32'h0000_C010, 4, "R2");
        check(2'd2, 32'h0000_0040, 4, "R2");
        // R8 unified and instruction data spaces
        do_write(16'hFF0E, 16'h1005);
        check(2'd1, 32'h0000_C123, 'h8000, "R8");
        do_write(16'hFF0E, 16'h03FF);
        check(2'd0, 32'h1000_FFF8, 4, "R8");
        // R11 instruction maps
        do_write(16'hFF02, 16'h0005);
        check(2'd2, 32'h0002_0010, 4, "R11");
        do_write(16'hFF00, 16'h2000);
        check(2'd2, 32'h0000_0100, 4, "R11");
        // R12 test window
        do_write(16'hFF00, 16'h3000);
        check(2'd2, 32'h0000_17FC, 'h10, "R12");
        check(2'd0, 32'h1100_0800, 'h1000, "R12");
        // R4 register page fixup
        check(2'd0, 32'h0200_FF04, 2, "R4");
        check(2'd0, 32'h0205_FF20, 2, "R4");
        do_write(16'hFF08, 16'h2000);
        check(2'd1, 32'h0000_FF04, 2, "R4");

        // constrained random mix
        for (int it = 0; it < 4000; it++) begin
            logic [1:0] k;
            logic [31:0] a;
            longint ln;
            int pick;
            if ($urandom % 6 == 0) begin
                logic [15:0] wa;
                pick = int'($urandom % 10);
                wa = (pick < 8) ? 16'hFF00 + 16'(2 * pick) : (pick == 8 ? 16'hFF09 : 16'($urandom));
                do_write(wa, 16'($urandom));
            end
            pick = int'($urandom % 10);
            k = (pick < 6) ? 2'd0 : 2'(1 + ($urandom % 3));
            pick = int'($urandom % 6);
            case (pick)
                0: a = 32'h0000_0000;
                1: a = 32'h0100_0000;
                2: a = 32'h0200_0000;
                3: a = 32'h1000_0000;
                4: a = 32'h1100_0000;
                default: a = {8'($urandom), 24'h0};
            endcase
            a[23:0] = 24'($urandom);
            if ($urandom % 2 == 0) a[23:0] = a[23:0] & ((k == 2'd2 || a[31:24] == 8'h11) ? 24'h07FFFF : 24'h01FFFF);
            if ($urandom % 8 == 0) a[15:0] = {8'hFF, 4'h0, 4'($urandom)};
            ln = ($urandom % 2 == 0) ? longint'($urandom % 'h40000) : longint'($urandom % 'h40);
            check(k, a, ln, "");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule